// File: doc/BRIEF.md
# SDRAM Burst Data Engine Model

This block is a synthesizable, device-side model of a single SDRAM's burst data path, meant to sit opposite a memory controller as a checkable target. It decodes commands from the four active-low strobes, holds one open row per bank, stores words in a small internal array and plays back read and write bursts with a column counter, a programmable read latency of two or three cycles, byte-lane masking, burst stop, burst interruption and endless whole-page bursts.

The bidirectional data bus is split into an input word, an output word and an output enable. The data path has no valid/ready handshake and accepts no back-pressure: the protocol is fixed-latency. A write beat is taken on every rising edge of an active write burst, and a read beat is presented on a fixed cycle whether or not the far side is ready. `dq_oe` plays the role of the valid flag on the read side. Bursts can only be ended by a command.

Top module: `sdr_burst_model`

## Requirements
- R1: Out of reset `dq_oe` is low and `dq_out` is zero, no bank has an open row, burst length is 4 and read latency is 2.
- R2: Commands are sampled on the rising edge as {cs_n,ras_n,cas_n,we_n}: 0011 activate (row from the low address bits), 0101 read, 0100 write, 0110 burst stop, 0010 close row of bank `ba`, 0000 mode load. Any pattern with cs_n high is a no-op. A read or write to a bank without an open row is ignored entirely and does not disturb a running burst.
- R3: Mode load takes the burst length from addr[2:0] (0:1, 1:2, 2:4, 3:8, 7:whole page, other codes act as 1) and the read latency from addr[4] (0: two cycles, 1: three cycles).
- R4: A write stores `dq_in` at the command's column on the edge that registers the command. Beat i is taken on the i-th later edge. Columns advance by one and wrap inside the block of burst-length size that holds the start column.
- R5: A read beat issued on edge E+i (E = read edge) appears on `dq_out` with `dq_oe` high after edge E+i+L-1, where L is the latency. With no beat due, `dq_oe` is low and `dq_out` is zero.
- R6: `dqm` high on the edge that takes a write beat leaves that word unchanged. `dqm` high on edge E+i blanks read beat i (`dq_oe` low in its output cycle).
- R7: A read during a read burst drops the old burst's unissued beats. The new beats follow the already issued ones back to back at the same latency.
- R8: A read during a write burst ends the write: `dq_in` on the read edge and after it is not stored.
- R9: Burst stop during a read issues no beat from the stop edge B on. `dq_oe` is low from edge B+L-1.
- R10: Burst stop during a write ends it: `dq_in` on the stop edge and after it is not stored.
- R11: In whole-page mode, read and write bursts wrap from the last column to column 0 and continue until a stop, read or write ends them.
- R12: Write data after the last beat of a burst of programmed length is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Row, column or mode value |
| dqm | input | 1 | Data mask for the beat taken or issued on this edge |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data, zero when not driven |
| dq_oe | output | 1 | Read data valid / output enable |

## Verification
Every write is checked by a later read. Each read beat is compared in the falling-edge sample that follows edge E+i+L-1: one edge after its issue at latency two and two edges after at latency three. The cycles before and after a burst are checked for a low enable, so a beat that comes early or late fails. Stop, interrupt and mask cases count edges from the command that ends or blanks the beat and check both the last expected beat and the first silent cycle. Every input is driven and every output sampled on the falling edge, half a period away from the edge that moves the design.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_MRS, CMD_REF
  } sdr_cmd_e;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       cl3;
  } sdr_mode_t;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdr_cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = CMD_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_burst_seq.sv
// Column sequencer shared by the read and write sides.
module sdr_burst_seq #(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             skip,      // begin one column past first_col
  input  logic             full,      // endless whole-page burst
  input  logic [COL_W:0]   beats,     // beats still to run after start
  input  logic [COL_W-1:0] first_col,
  input  logic [COL_W-1:0] wrap_mask,
  output logic             act,
  output logic [COL_W-1:0] col
);
  logic [COL_W:0] left;

  function automatic logic [COL_W-1:0] step(input logic [COL_W-1:0] c,
                                            input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      col  <= '0;
      left <= '0;
    end else if (start) begin
      act  <= full || (beats != '0);
      col  <= skip ? step(first_col, wrap_mask) : first_col;
      left <= beats - 1'b1;
    end else if (stop) begin
      act <= 1'b0;
    end else if (act) begin
      if (full || left != '0) begin
        col  <= step(col, wrap_mask);
        left <= left - 1'b1;
      end else begin
        act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
// Read latency pipeline; lat_sel 0 gives the shortest latency.
module sdr_rd_pipe #(
  parameter int DW     = 8,
  parameter int MAX_CL = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    lat_sel,
  input  logic                in_vld,
  input  logic [DW-1:0]       in_dat,
  output logic                out_vld,
  output logic [DW-1:0]       out_dat
);
  localparam int STAGES = MAX_CL - 1;
  localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [STAGES-1:0] vld;
  logic [DW-1:0]     dat [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < STAGES; s++) dat[s] <= '0;
    end else begin
      vld[0] <= in_vld;
      dat[0] <= in_dat;
      for (int s = 1; s < STAGES; s++) begin
        vld[s] <= vld[s-1];
        dat[s] <= dat[s-1];
      end
    end
  end

  generate
    if (STAGES == 1) begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^lat_sel;
      assign out_vld = vld[0];
      assign out_dat = dat[0];
    end else begin : g_select
      assign out_vld = vld[lat_sel];
      assign out_dat = dat[lat_sel];
    end
  endgenerate
endmodule

// File: rtl/sdr_burst_model.sv
module sdr_burst_model
  import sdr_pkg::*;
#(
  parameter int BA_W   = 1,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe
);
  localparam int NBANK  = 1 << BA_W;
  localparam int IDX_W  = BA_W + ROW_W + COL_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MAX_CL = 3;

  sdr_cmd_e  cmd;
  sdr_mode_t mode;
  logic [NBANK-1:0] row_open;
  logic [ROW_W-1:0] open_row [NBANK];
  logic [DQ_W-1:0]  mem [DEPTH];

  logic             bank_ok, rd_go, wr_go, bst, full_page, cl3;
  logic [COL_W-1:0] len_mask, rd_col, wr_col, cmd_col;
  logic [COL_W:0]   rd_beats, wr_beats;
  logic             rd_act, wr_act, rd_mask_r;
  logic [BA_W-1:0]  rd_bank, wr_bank;
  logic [ROW_W-1:0] rd_row, wr_row;
  logic             pipe_vld;
  logic [DQ_W-1:0]  pipe_dat;
  logic             unused_addr;

  sdr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign unused_addr = ^addr;
  assign cmd_col   = addr[COL_W-1:0];
  assign bank_ok   = row_open[ba];
  assign rd_go     = (cmd == CMD_RD) && bank_ok;
  assign wr_go     = (cmd == CMD_WR) && bank_ok;
  assign bst       = (cmd == CMD_BST);
  assign full_page = (mode.bl_code == 3'd7);
  assign cl3       = mode.cl3;

  always_comb begin
    case (mode.bl_code)
      3'd1:    len_mask = COL_W'(1);
      3'd2:    len_mask = COL_W'(3);
      3'd3:    len_mask = COL_W'(7);
      3'd7:    len_mask = '1;
      default: len_mask = '0;
    endcase
  end
  assign rd_beats = {1'b0, len_mask} + 1'b1;
  assign wr_beats = {1'b0, len_mask};

  // mode, open rows, burst bank/row capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= '{bl_code: 3'd2, cl3: 1'b0};
      row_open  <= '0;
      for (int b = 0; b < NBANK; b++) open_row[b] <= '0;
      rd_bank   <= '0;
      rd_row    <= '0;
      wr_bank   <= '0;
      wr_row    <= '0;
      rd_mask_r <= 1'b0;
    end else begin
      rd_mask_r <= dqm;
      case (cmd)
        CMD_MRS: mode <= '{bl_code: addr[2:0], cl3: addr[4]};
        CMD_ACT: begin
          row_open[ba] <= 1'b1;
          open_row[ba] <= addr[ROW_W-1:0];
        end
        CMD_PRE: row_open[ba] <= 1'b0;
        default: ;
      endcase
      if (rd_go) begin
        rd_bank <= ba;
        rd_row  <= open_row[ba];
      end
      if (wr_go) begin
        wr_bank <= ba;
        wr_row  <= open_row[ba];
      end
    end
  end

  sdr_burst_seq #(.COL_W(COL_W)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .start(rd_go), .stop(wr_go || bst),
    .skip(1'b0), .full(full_page), .beats(rd_beats), .first_col(cmd_col),
    .wrap_mask(len_mask), .act(rd_act), .col(rd_col)
  );

  sdr_burst_seq #(.COL_W(COL_W)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .stop(rd_go || bst),
    .skip(1'b1), .full(full_page), .beats(wr_beats), .first_col(cmd_col),
    .wrap_mask(len_mask), .act(wr_act), .col(wr_col)
  );

  // storage: first beat on the command edge, later beats from the sequencer
  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (!dqm) mem[{ba, open_row[ba], cmd_col}] <= dq_in;
    end else if (wr_act && !(rd_go || bst) && !dqm) begin
      mem[{wr_bank, wr_row, wr_col}] <= dq_in;
    end
  end

  sdr_rd_pipe #(.DW(DQ_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .lat_sel(cl3),
    .in_vld(rd_act && !rd_mask_r), .in_dat(mem[{rd_bank, rd_row, rd_col}]),
    .out_vld(pipe_vld), .out_dat(pipe_dat)
  );

  assign dq_oe  = pipe_vld;
  assign dq_out = pipe_vld ? pipe_dat : '0;
endmodule

// File: rtl/sdr_burst_checker.sv
module sdr_burst_checker
  import sdr_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input sdr_cmd_e cmd,
  input logic     bank_ok,
  input logic     rd_act,
  input logic     wr_act,
  input logic     cl3,
  input logic     full_page,
  input logic     dq_oe
);
  // R5: enabled output at latency two comes from a beat issued one cycle back
  assert_lat2_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !cl3 && $past(!cl3)) |-> $past(rd_act));

  // R5: at latency three the beat was issued two cycles back
  assert_lat3_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && cl3 && $past(cl3) && $past(cl3, 2)) |-> $past(rd_act, 2));

  // R9: burst stop leaves no read beat being issued
  assert_stop_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_BST) |=> !rd_act);

  // R8: an accepted read ends a write burst
  assert_read_ends_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && bank_ok) |=> !wr_act);

  // R2: a read to a closed bank starts nothing
  assert_closed_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && !bank_ok && !rd_act) |=> !rd_act);

  // R11: whole-page reads keep going across idle cycles
  assert_page_endless_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_page && $past(full_page) && $past(rd_act) && $past(cmd) == CMD_NOP)
      |-> rd_act);
endmodule

bind sdr_burst_model sdr_burst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank_ok(bank_ok), .rd_act(rd_act),
  .wr_act(wr_act), .cl3(cl3), .full_page(full_page), .dq_oe(dq_oe)
);

// File: tb/sdr_burst_model_test.sv
module sdr_burst_model_test;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_BST = 4'b0110, C_PRE = 4'b0010,
                         C_MRS = 4'b0000, C_DES = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, dqm, dq_oe;
  logic [0:0] ba;
  logic [7:0] addr, dq_in, dq_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sdr_burst_model uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {cmd, ba, addr, dqm, din, exp_oe, exp_dout, req}
  localparam int NV = 18;
  localparam logic [34:0] TBL [NV] = '{
    {C_MRS, 1'b0, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 4'd3},  // R3 BL4 lat2
    {C_ACT, 1'b0, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, 4'd2},
    {C_WR,  1'b0, 8'h02, 1'b0, 8'h11, 1'b0, 8'h00, 4'd4},  // R4 start col2
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h22, 1'b0, 8'h00, 4'd4},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h33, 1'b0, 8'h00, 4'd4},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h44, 1'b0, 8'h00, 4'd4},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h99, 1'b0, 8'h00, 4'd12}, // R12 extra beat
    {C_RD,  1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 4'd5},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33, 4'd4},  // R4 wrapped beat
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h44, 4'd4},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h11, 4'd12}, // R12 not 99
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h22, 4'd5},
    {C_RD,  1'b0, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 4'd5},  // R5 idle
    {C_NOP, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 8'h11, 4'd5},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 4'd6},  // R6 beat1 blanked
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33, 4'd6},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h44, 4'd5},
    {C_NOP, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 4'd5}
  };

  task automatic drive(input logic [3:0] c, input logic b, input logic [7:0] a,
                       input logic m, input logic [7:0] d);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = a; dqm = m; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input logic [7:0] d);
    drive(C_NOP, 1'b0, 8'h00, 1'b0, d);
  endtask

  task automatic chk(input logic eoe, input logic [7:0] ed, input string req);
    checks++;
    if (dq_oe !== eoe || dq_out !== (eoe ? ed : 8'h00)) begin
      errors++;
      $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h",
               req, dq_oe, dq_out, eoe, eoe ? ed : 8'h00);
    end
  endtask

  // read n beats, beat i expected in exp[8*i +: 8]
  task automatic rd_seq(input logic b, input logic [7:0] col, input int lat,
                        input int n, input logic [79:0] exp, input string req);
    drive(C_RD, b, col, 1'b0, 8'h00);
    chk(1'b0, 8'h00, req);
    for (int j = 1; j <= lat - 2; j++) begin
      nop(8'h00);
      chk(1'b0, 8'h00, req);
    end
    for (int i = 0; i < n; i++) begin
      nop(8'h00);
      chk(1'b1, exp[8*i +: 8], req);
    end
    nop(8'h00);
    chk(1'b0, 8'h00, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba = '0; addr = '0; dqm = 1'b0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1'b0, 8'h00, "R1");

    // R1 defaults: BL4, latency two, without a mode load
    drive(C_ACT, 1'b1, 8'h02, 1'b0, 8'h00);
    drive(C_WR,  1'b1, 8'h04, 1'b0, 8'hA4);
    nop(8'hA5); nop(8'hA6); nop(8'hA7);
    rd_seq(1'b1, 8'h04, 2, 4, {48'h0, 8'hA7, 8'hA6, 8'hA5, 8'hA4}, "R1");

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v][34:31], TBL[v][30], TBL[v][29:22], TBL[v][21], TBL[v][20:13]);
      chk(TBL[v][12], TBL[v][11:4], $sformatf("R%0d", TBL[v][3:0]));
    end

    // R2: closed bank ignores read and write; deselected write ignored
    drive(C_PRE, 1'b1, 8'h00, 1'b0, 8'h00);
    drive(C_RD,  1'b1, 8'h04, 1'b0, 8'h00);
    for (int j = 0; j < 3; j++) begin nop(8'h00); chk(1'b0, 8'h00, "R2"); end
    drive(C_WR,  1'b1, 8'h04, 1'b0, 8'hEE);
    nop(8'hEF);
    drive(C_ACT, 1'b1, 8'h02, 1'b0, 8'h00);
    rd_seq(1'b1, 8'h04, 2, 4, {48'h0, 8'hA7, 8'hA6, 8'hA5, 8'hA4}, "R2");
    drive(C_DES, 1'b0, 8'h00, 1'b0, 8'hDD);
    chk(1'b0, 8'h00, "R2");

    // R3: BL2, latency three
    drive(C_MRS, 1'b0, 8'h11, 1'b0, 8'h00);
    rd_seq(1'b0, 8'h00, 3, 2, {64'h0, 8'h44, 8'h33}, "R3");

    // R7: read interrupted by read, BL4 latency three
    drive(C_MRS, 1'b0, 8'h12, 1'b0, 8'h00);
    drive(C_RD, 1'b0, 8'h00, 1'b0, 8'h00); chk(1'b0, 8'h00, "R7");
    drive(C_RD, 1'b0, 8'h02, 1'b0, 8'h00); chk(1'b0, 8'h00, "R7");
    nop(8'h00); chk(1'b1, 8'h33, "R7");
    nop(8'h00); chk(1'b1, 8'h11, "R7");
    nop(8'h00); chk(1'b1, 8'h22, "R7");
    nop(8'h00); chk(1'b1, 8'h33, "R7");
    nop(8'h00); chk(1'b1, 8'h44, "R7");
    nop(8'h00); chk(1'b0, 8'h00, "R7");

    // R8: write interrupted by read, BL4 latency two
    drive(C_MRS, 1'b0, 8'h02, 1'b0, 8'h00);
    drive(C_WR, 1'b0, 8'h00, 1'b0, 8'h50);
    nop(8'h51);
    drive(C_RD, 1'b1, 8'h04, 1'b0, 8'h52); chk(1'b0, 8'h00, "R8");
    nop(8'h53); chk(1'b1, 8'hA4, "R8");
    nop(8'h54); chk(1'b1, 8'hA5, "R8");
    nop(8'h00); chk(1'b1, 8'hA6, "R8");
    nop(8'h00); chk(1'b1, 8'hA7, "R8");
    nop(8'h00); chk(1'b0, 8'h00, "R8");
    rd_seq(1'b0, 8'h00, 2, 4, {48'h0, 8'h22, 8'h11, 8'h51, 8'h50}, "R8");

    // R10: burst stop during write
    drive(C_WR, 1'b0, 8'h00, 1'b0, 8'h60);
    nop(8'h61);
    drive(C_BST, 1'b0, 8'h00, 1'b0, 8'h62);
    nop(8'h63); nop(8'h64);
    rd_seq(1'b0, 8'h00, 2, 4, {48'h0, 8'h22, 8'h11, 8'h61, 8'h60}, "R10");

    // R9: burst stop during read, latency two
    drive(C_RD, 1'b1, 8'h04, 1'b0, 8'h00); chk(1'b0, 8'h00, "R9");
    nop(8'h00); chk(1'b1, 8'hA4, "R9");
    drive(C_BST, 1'b0, 8'h00, 1'b0, 8'h00); chk(1'b1, 8'hA5, "R9");
    nop(8'h00); chk(1'b0, 8'h00, "R9");
    nop(8'h00); chk(1'b0, 8'h00, "R9");

    // R6: masked write beat keeps the old word
    drive(C_WR, 1'b0, 8'h00, 1'b0, 8'h70);
    drive(C_NOP, 1'b0, 8'h00, 1'b1, 8'h71);
    nop(8'h72); nop(8'h73); nop(8'h00);
    rd_seq(1'b0, 8'h00, 2, 4, {48'h0, 8'h73, 8'h72, 8'h61, 8'h70}, "R6");

    // R11: whole-page write and read wrap until stopped
    drive(C_MRS, 1'b0, 8'h07, 1'b0, 8'h00);
    drive(C_WR, 1'b0, 8'h06, 1'b0, 8'h80);
    for (int k = 1; k <= 9; k++) nop(8'h80 + 8'(k));
    drive(C_BST, 1'b0, 8'h00, 1'b0, 8'h8A);
    nop(8'h8B);
    drive(C_RD, 1'b0, 8'h00, 1'b0, 8'h00); chk(1'b0, 8'h00, "R11");
    for (int j = 1; j <= 10; j++) begin
      nop(8'h00);
      chk(1'b1, 8'h82 + 8'((j - 1) % 8), "R11");
    end
    drive(C_BST, 1'b0, 8'h00, 1'b0, 8'h00); chk(1'b1, 8'h84, "R11");
    nop(8'h00); chk(1'b0, 8'h00, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule